// File: doc/BRIEF.md
# Held Control Register Bank with Frame-Aligned Release

This block sits between a serial-bus register file and the picture-processing functions. It keeps two copies of a group of control fields: a staging copy that register writes land in, and an active copy that drives the picture logic. The active copy of this held group changes only at a rising edge of the main-channel vertical sync. A hold input lets software stop those transfers. Software can then rewrite positions, sizes, enables and other related fields across several bus transactions. When hold is released, the whole set takes effect together at the next vertical sync. No frame ever shows a mix of old and new settings.

A second, smaller group of registers is not subject to this mechanism. Writes to that group reach its outputs on the next clock, whatever the hold and sync inputs do.

The address space is split in two. Addresses `0 .. NUM_HELD-1` select the held fields. Addresses `NUM_HELD .. NUM_HELD+NUM_FREE-1` select the direct fields. Any other address is ignored. Field `k` of each output bus occupies bits `[k*DATA_W +: DATA_W]`. The reset input is asynchronous, active low, and is released into the block through a two-stage synchroniser.

Top module: `hold_release_bank`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, every held and direct output is 0, and the staging copy is 0 too, so a later sync transfer still yields 0.
- R2: While `hold_i` is 1 in the cycle where a vertical-sync rising edge is seen, the held outputs keep their value; writes to held addresses during hold do not reach `held_o`.
- R3: When a vertical-sync rising edge (vsync 1 in this cycle, 0 in the previous) is seen with `hold_i` at 0, all held outputs take the staged values at that same clock edge, all fields together.
- R4: With `hold_i` at 0, a write to a held address does not appear on `held_o` until the next vertical-sync rising edge.
- R5: A write to a direct address (`NUM_HELD` upward) appears on its field of `free_o` after one clock, independent of `hold_i` and `vsync_i`.
- R6: Writes to held addresses never change `free_o`, and writes to direct addresses never change the staging copy or `held_o`.
- R7: A held write in the same cycle as a transfer is stored in staging; the transfer carries the previous staged value, and the new value appears at the following rising edge.
- R8: Only the rising edge of `vsync_i` transfers; a write made while vsync stays high waits for the next rising edge.
- R9: Writes to addresses at or above `NUM_HELD+NUM_FREE` change no output.
- R10: Hold is judged only in the edge cycle: clearing hold while vsync stays high causes no transfer until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| hold_i | input | 1 | Freeze held-group transfers when 1 |
| vsync_i | input | 1 | Main-channel vertical sync, synchronous level |
| held_o | output | NUM_HELD*DATA_W | Active copy of the held fields |
| free_o | output | NUM_FREE*DATA_W | Direct (unheld) fields |

## Verification
The bench exercises the block with several distinct patterns:
- Writes with hold low and no sync edge. These separate staging from active and show that a write is deferred.
- Writes with hold high, followed by a sync edge. These show that the edge is gated.
- Hold cleared while sync stays high. This separates an edge-triggered transfer from a level-triggered one.
- A write in the very cycle of a transfer. This shows that old data is transferred and new data is captured.

Direct-field and out-of-range writes are interleaved with the held traffic so that cross-group leakage would show. A mid-run reset followed by a bare sync edge confirms that the staging copy was cleared as well as the outputs.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Default geometry of the register bank
  localparam int HB_DATA_W   = 8;
  localparam int HB_NUM_HELD = 4;
  localparam int HB_NUM_FREE = 2;
  localparam int HB_ADDR_W   = 4;
  // Depth of the reset release synchroniser
  localparam int HB_RST_STAGES = 2;
endpackage

// File: rtl/hb_reset_sync.sv
module hb_reset_sync #(
  parameter int STAGES = hb_pkg::HB_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/hb_sync_edge.sv
module hb_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
  end

  // Reset to 1: a sync already high when reset lifts is not a fresh edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/hb_addr_decode.sv
module hb_addr_decode #(
  parameter int ADDR_W   = hb_pkg::HB_ADDR_W,
  parameter int NUM_HELD = hb_pkg::HB_NUM_HELD,
  parameter int NUM_FREE = hb_pkg::HB_NUM_FREE
) (
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  output logic [NUM_HELD-1:0] held_we_o,
  output logic [NUM_FREE-1:0] free_we_o
);
  // One strobe per field; addresses matching no field raise no strobe.
  for (genvar h = 0; h < NUM_HELD; h++) begin : g_held
    assign held_we_o[h] = wr_en_i && (wr_addr_i == ADDR_W'(h));
  end

  for (genvar f = 0; f < NUM_FREE; f++) begin : g_free
    assign free_we_o[f] = wr_en_i && (wr_addr_i == ADDR_W'(NUM_HELD + f));
  end
endmodule

// File: rtl/hb_field_bank.sv
module hb_field_bank #(
  parameter int DATA_W  = hb_pkg::HB_DATA_W,
  parameter int ENTRIES = hb_pkg::HB_NUM_HELD,
  localparam int BUS_W  = DATA_W * ENTRIES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] load_i,
  input  logic [BUS_W-1:0]   data_i,
  output logic [BUS_W-1:0]   q_o
);
  logic [BUS_W-1:0] d_q;
  logic [BUS_W-1:0] d_next;

  always_comb begin
    d_next = d_q;
    for (int k = 0; k < ENTRIES; k++) begin
      if (load_i[k]) begin
        d_next[k*DATA_W +: DATA_W] = data_i[k*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[k*DATA_W +: DATA_W] <= '0;
      end else if (load_i[k]) begin
        d_q[k*DATA_W +: DATA_W] <= d_next[k*DATA_W +: DATA_W];
      end
    end
  end

  assign q_o = d_q;
endmodule

// File: rtl/hold_release_bank.sv
module hold_release_bank #(
  parameter int DATA_W   = hb_pkg::HB_DATA_W,
  parameter int NUM_HELD = hb_pkg::HB_NUM_HELD,
  parameter int NUM_FREE = hb_pkg::HB_NUM_FREE,
  parameter int ADDR_W   = hb_pkg::HB_ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         hold_i,
  input  logic                         vsync_i,
  output logic [NUM_HELD*DATA_W-1:0]   held_o,
  output logic [NUM_FREE*DATA_W-1:0]   free_o
);
  localparam int HELD_W = NUM_HELD * DATA_W;
  localparam int FREE_W = NUM_FREE * DATA_W;

  logic                rst_int_n;
  logic                vs_rise;
  logic                xfer;
  logic [NUM_HELD-1:0] held_we;
  logic [NUM_FREE-1:0] free_we;
  logic [HELD_W-1:0]   stage_q;

  hb_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  hb_sync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (vsync_i),
    .rise_o  (vs_rise)
  );

  // Transfer only on a sync rising edge seen while hold is low.
  assign xfer = vs_rise & ~hold_i;

  hb_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HELD (NUM_HELD),
    .NUM_FREE (NUM_FREE)
  ) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .held_we_o (held_we),
    .free_we_o (free_we)
  );

  // Staging copy: written directly by the bus.
  hb_field_bank #(
    .DATA_W  (DATA_W),
    .ENTRIES (NUM_HELD)
  ) u_stage (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (held_we),
    .data_i ({NUM_HELD{wr_data_i}}),
    .q_o    (stage_q)
  );

  // Active copy: every field loaded in the same clock.
  hb_field_bank #(
    .DATA_W  (DATA_W),
    .ENTRIES (NUM_HELD)
  ) u_active (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i ({NUM_HELD{xfer}}),
    .data_i (stage_q),
    .q_o    (held_o)
  );

  // Direct fields: no staging, no sync alignment.
  hb_field_bank #(
    .DATA_W  (DATA_W),
    .ENTRIES (NUM_FREE)
  ) u_free (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (free_we),
    .data_i ({NUM_FREE{wr_data_i}}),
    .q_o    (free_o)
  );

  if (FREE_W <= 0 || HELD_W <= 0) begin : g_bad_geom
    initial $error("hold_release_bank: empty register group");
  end
endmodule

// File: rtl/hold_release_bank_chk.sv
module hold_release_bank_chk #(
  parameter int DATA_W   = hb_pkg::HB_DATA_W,
  parameter int NUM_HELD = hb_pkg::HB_NUM_HELD,
  parameter int NUM_FREE = hb_pkg::HB_NUM_FREE,
  parameter int ADDR_W   = hb_pkg::HB_ADDR_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic                       hold_i,
  input logic                       vsync_i,
  input logic [NUM_HELD*DATA_W-1:0] held_o,
  input logic [NUM_FREE*DATA_W-1:0] free_o,
  input logic [NUM_HELD*DATA_W-1:0] stage_q
);
  localparam logic [ADDR_W:0] HELD_END = (ADDR_W+1)'(NUM_HELD);
  localparam logic [ADDR_W:0] ALL_END  = (ADDR_W+1)'(NUM_HELD + NUM_FREE);

  logic [ADDR_W:0] addr_x;
  logic            wr_held;
  logic            wr_free;
  logic            wr_none;

  assign addr_x  = {1'b0, wr_addr_i};
  assign wr_held = wr_en_i && (addr_x < HELD_END);
  assign wr_free = wr_en_i && (addr_x >= HELD_END) && (addr_x < ALL_END);
  assign wr_none = wr_en_i && (addr_x >= ALL_END);

  a_r2_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(held_o));

  a_r3_edge_loads_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && !$past(vsync_i) && !hold_i) |=> (held_o == $past(stage_q)));

  a_r8_change_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_o) |-> ($past(vsync_i) && !$past(vsync_i, 2) && !$past(hold_i)));

  a_r6_free_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(free_o) |-> $past(wr_free));

  a_r6_stage_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stage_q) |-> $past(wr_held));

  a_r9_stray_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_none |=> $stable(free_o) && $stable(stage_q));
endmodule

bind hold_release_bank hold_release_bank_chk #(
  .DATA_W   (DATA_W),
  .NUM_HELD (NUM_HELD),
  .NUM_FREE (NUM_FREE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .hold_i    (hold_i),
  .vsync_i   (vsync_i),
  .held_o    (held_o),
  .free_o    (free_o),
  .stage_q   (stage_q)
);

// File: tb/hold_release_bank_tb.sv
module hold_release_bank_tb;
  localparam int DW = 8;
  localparam int NH = 4;
  localparam int NF = 2;
  localparam int AW = 4;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          hold;
  logic          vsync;
  logic [NH*DW-1:0] held;
  logic [NF*DW-1:0] free;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hold_release_bank #(.DATA_W(DW), .NUM_HELD(NH), .NUM_FREE(NF), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hold_i(hold), .vsync_i(vsync),
    .held_o(held), .free_o(free)
  );

  // {hold, wr_en, addr[3:0], data[7:0], vsync, exp_held[31:0], exp_free[15:0]}
  // Expected values hold after the clock edge following each row.
  localparam logic [62:0] VEC [NV] = '{
    {1'b0,1'b1,4'd0,8'h11,1'b0,32'h00000000,16'h0000}, // R4 write deferred
    {1'b0,1'b1,4'd3,8'h44,1'b0,32'h00000000,16'h0000}, // R4
    {1'b0,1'b0,4'd0,8'h00,1'b1,32'h44000011,16'h0000}, // R3 rising edge
    {1'b0,1'b1,4'd1,8'h22,1'b1,32'h44000011,16'h0000}, // R8 level high
    {1'b0,1'b0,4'd0,8'h00,1'b0,32'h44000011,16'h0000}, // R8
    {1'b1,1'b1,4'd2,8'h33,1'b0,32'h44000011,16'h0000}, // R2 write under hold
    {1'b1,1'b0,4'd0,8'h00,1'b1,32'h44000011,16'h0000}, // R2 edge blocked
    {1'b0,1'b0,4'd0,8'h00,1'b1,32'h44000011,16'h0000}, // R10 hold clears, no edge
    {1'b0,1'b0,4'd0,8'h00,1'b0,32'h44000011,16'h0000}, // R10
    {1'b0,1'b1,4'd4,8'h55,1'b1,32'h44332211,16'h0055}, // R3 R5 edge + direct write
    {1'b1,1'b1,4'd5,8'h66,1'b0,32'h44332211,16'h6655}, // R5 R6 direct under hold
    {1'b1,1'b1,4'd6,8'h77,1'b0,32'h44332211,16'h6655}, // R9 stray address
    {1'b0,1'b1,4'd0,8'h99,1'b1,32'h44332211,16'h6655}, // R7 write in transfer cycle
    {1'b0,1'b0,4'd0,8'h00,1'b0,32'h44332211,16'h6655}, // R7
    {1'b0,1'b0,4'd0,8'h00,1'b1,32'h44332299,16'h6655}  // R7 applied next edge
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic h, input logic we, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic v);
    hold = h; wr_en = we; wr_addr = a; wr_data = d; vsync = v;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hold = 0; wr_en = 0; wr_addr = '0; wr_data = '0; vsync = 0;
    repeat (3) @(posedge clk); #1;
    check("R1 held in reset", held, 32'h0);
    check("R1 free in reset", {16'h0, free}, 32'h0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, '0, '0, 0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][62], VEC[i][61], VEC[i][60:57], VEC[i][56:49], VEC[i][48]);
      check($sformatf("row%0d held R2/R3/R4/R7/R8/R10", i), held, VEC[i][47:16]);
      check($sformatf("row%0d free R5/R6/R9", i), {16'h0, free}, {16'h0, VEC[i][15:0]});
    end

    // R1: asynchronous reset clears outputs at once, and staging too.
    #1 rst_n = 1'b0; #1;
    check("R1 async held", held, 32'h0);
    check("R1 async free", {16'h0, free}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) cyc(0, 0, '0, '0, 0);
    cyc(0, 0, '0, '0, 1);
    check("R1 staging cleared", held, 32'h0);
    cyc(0, 0, '0, '0, 0);

    // R6: direct write leaves staging untouched; R2 then R3 on the next free edge.
    cyc(1, 1, 4'd1, 8'hAB, 0);
    cyc(1, 1, 4'd5, 8'hCD, 0);
    check("R6 free after direct", {16'h0, free}, 32'h0000CD00);
    cyc(1, 0, '0, '0, 1);
    check("R2 hold at edge", held, 32'h0);
    cyc(0, 0, '0, '0, 0);
    cyc(0, 0, '0, '0, 1);
    check("R3 release transfer", held, 32'h0000AB00);
    check("R6 free unaffected", {16'h0, free}, 32'h0000CD00);
    // R9: top of address space
    cyc(0, 1, 4'hF, 8'hEE, 0);
    cyc(0, 0, '0, '0, 1);
    check("R9 addr 15 ignored held", held, 32'h0000AB00);
    check("R9 addr 15 ignored free", {16'h0, free}, 32'h0000CD00);

    finish_run();
  end
endmodule